// File: doc/BRIEF.md
# Address translation checker and fault reporter

This block sits between an access source (instruction fetch or load/store) and an external translation lookaside buffer. For each access presented with `acc_valid`, it settles within the same cycle on one of two results: a physical address or a fault code. It chooses the context from the trap level and the pre-decoded address-space class flags. It applies the hyperprivileged and reset-state bypass rules, checks alignment and the unimplemented virtual-address hole, and issues a lookup. On a hit it checks the page attributes.

Three registers hold the history of faults. A sticky status word records the most recent check fault and flags an overflow when the previous one was never cleared. A fault-address register keeps the virtual address of the last data-side fault. A miss-tag register keeps the page-aligned address and context of the last lookup miss. These registers change only on a valid access, except that `flt_clr` empties the status word. The full address-space identifier decode tables and the TLB storage stay outside the block: the identifier arrives as class flags, and the lookup answer comes back in the same cycle on the `tlb_*` inputs.

Top module: `xlate_guard`

## Requirements
- R1: Context selection. A nonzero trap level, or an explicit data access of nucleus class, selects context 0 with type code 2. Otherwise an explicit data access of secondary class selects `ctx_secondary` with type code 1. Every other case selects `ctx_primary` with type code 0. Instruction accesses never count as explicit. The recorded identifier is `asi_id` for explicit data accesses. For other accesses it is 8'h04 when the trap level is nonzero and 8'h80 otherwise.
- R2: An instruction access with `hpriv_mode` or `red_mode` set bypasses translation before any other check. It gives no fault, no lookup, and `pa_out` equal to the effective VA truncated to PA_W bits. A data access with `hpriv_mode` set bypasses in the same way when it is implicit, or when it is explicit with neither `asi_real` nor `asi_as_user` set. The data bypass only applies after the alignment and range checks have passed.
- R3: An alignment fault (code 1) is raised by an instruction access whose VA[2:0] is nonzero. It is also raised by a data access whose VA is not a multiple of 2^`acc_size_lg` bytes.
- R4: With `addr_mask` set, the effective VA is VA[31:0] zero-extended and the range check is skipped. With `addr_mask` clear, an effective VA inside [HOLE_LO, HOLE_HI] inclusive raises a range fault (code 2). The range check ranks below alignment.
- R5: A lookup is real, with `tlb_real` set and `tlb_ctx` equal to 0, when either of two conditions holds. On the instruction side the condition is `immu_on` clear. On the data side it is `dmmu_on` clear without `hpriv_mode`, or an explicit access with `asi_real` set.
- R6: A lookup that misses raises code 3 if it was real and code 4 if it was virtual. The next cycle, `miss_tag` holds the effective VA with its low PAGE_SHIFT bits cleared, ORed with the lookup context. `miss_tag` changes on no other event.
- R7: On a hit, checks run in this order. A data write to a page without `tlb_wr_ok` gives code 5. A data access to a `tlb_nofault` page without an explicit no-fault identifier gives code 6. A `tlb_priv` page accessed with `priv_mode` clear gives code 7. The no-fault-page and write checks apply only to data.
- R8: `uncacheable` is set only for a data access that completes a translation without fault on a page with `tlb_sidefx`.
- R9: A translation without fault sets `xlate_ok`. After a hit, `pa_out` is (`tlb_frame` AND NOT `tlb_pmask`) OR (effective VA AND `tlb_pmask`). `pa_out` is 0 whenever `xlate_ok` is low.
- R10: Codes 1, 2, 5, 6 and 7 write the status word on the next edge. The fields are: bit 0 valid = 1; bit 2 write = (data AND `acc_write`); bits 5:4 context type; bit 6 side effect; bits 12:7 fault type one-hot; bits 23:16 recorded identifier. The side-effect bit is 1 for a data range fault, `tlb_sidefx` for a data hit fault, and 0 otherwise. The fault type bits are: bit 7 privilege (code 7), bit 8 no-fault page (code 6), bit 9 range (code 2), and bit 10 other (codes 1 and 5). All other bits are 0.
- R11: When a status write occurs while bit 0 is already set and `flt_clr` is low, bit 1 (overflow) of the new word is 1. Otherwise it is 0.
- R12: `flt_addr` loads the raw `acc_va` on a status write caused by a data access and holds otherwise.
- R13: With `acc_valid` low, `fault_code` is 0, `tlb_req`, `xlate_ok` and `uncacheable` are 0, and `miss_tag` and `flt_addr` hold. `flt_stat` also holds unless `flt_clr` is set.
- R14: `flt_clr` alone zeroes `flt_stat` on the next edge. When it coincides with a status write, the new word is written with overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| acc_write | input | 1 | Data access is a store |
| acc_explicit | input | 1 | Data access carries an explicit identifier |
| acc_va | input | VA_W | Virtual address |
| acc_size_lg | input | 2 | log2 of the data access size in bytes |
| asi_id | input | 8 | Explicit identifier value |
| asi_nucleus | input | 1 | Identifier class: nucleus |
| asi_secondary | input | 1 | Identifier class: secondary |
| asi_real | input | 1 | Identifier class: real |
| asi_nofault | input | 1 | Identifier class: no-fault |
| asi_as_user | input | 1 | Identifier class: as-if-user |
| tl_nonzero | input | 1 | Trap level above zero |
| priv_mode | input | 1 | Privileged mode |
| hpriv_mode | input | 1 | Hyperprivileged mode |
| red_mode | input | 1 | Reset/error state |
| addr_mask | input | 1 | 32-bit address masking |
| immu_on | input | 1 | Instruction translation enable |
| dmmu_on | input | 1 | Data translation enable |
| ctx_primary | input | CTX_W | Primary context |
| ctx_secondary | input | CTX_W | Secondary context |
| tlb_req | output | 1 | Lookup request |
| tlb_va | output | VA_W | Lookup virtual address |
| tlb_ctx | output | CTX_W | Lookup context |
| tlb_real | output | 1 | Lookup is real |
| tlb_hit | input | 1 | Lookup hit |
| tlb_frame | input | PA_W | Physical frame of the hit entry |
| tlb_pmask | input | PA_W | Page offset mask of the hit entry |
| tlb_wr_ok | input | 1 | Page writable |
| tlb_nofault | input | 1 | Page is no-fault only |
| tlb_sidefx | input | 1 | Page has side effects |
| tlb_priv | input | 1 | Page privileged |
| flt_clr | input | 1 | Clear the status word |
| fault_code | output | 4 | Fault code, 0 = none |
| xlate_ok | output | 1 | Translation produced |
| pa_out | output | PA_W | Physical address |
| uncacheable | output | 1 | Access must bypass caches |
| flt_stat | output | 24 | Sticky fault status word |
| flt_addr | output | VA_W | Last data fault address |
| miss_tag | output | VA_W | Last miss tag |

## Verification
Clearing the status word and recording a new fault can fall in the same cycle. So can a new fault and a still-set valid bit, and together these decide the overflow bit. The bench drives a fault twice without a clear, then a lone clear, then a clear in the very cycle of a fault. It expects overflow on the first case and a fresh word with overflow 0 on the last. Several checks can also fire on one access: a misaligned fetch inside the hole under hyperprivilege, or a store to a page that is read-only, no-fault and privileged at once. In these cases the reported code is judged against the priority order alone.

// File: rtl/xg_pkg.sv
package xg_pkg;

  localparam int FT_W    = 6;
  localparam int STAT_W  = 24;
  localparam int TAG_W8  = 8;

  typedef enum logic [3:0] {
    XF_NONE      = 4'd0,
    XF_ALIGN     = 4'd1,
    XF_RANGE     = 4'd2,
    XF_MISS_REAL = 4'd3,
    XF_MISS_VIRT = 4'd4,
    XF_PROTECT   = 4'd5,
    XF_NOFAULT   = 4'd6,
    XF_PRIV      = 4'd7
  } xg_fault_e;

  typedef enum logic [1:0] {
    XC_PRIMARY   = 2'd0,
    XC_SECONDARY = 2'd1,
    XC_NUCLEUS   = 2'd2
  } xg_ctype_e;

  // one-hot fault type placed at status bits 12:7
  function automatic logic [FT_W-1:0] xg_ftype(input xg_fault_e f);
    logic [FT_W-1:0] t;
    t = '0;
    case (f)
      XF_PRIV:              t[0] = 1'b1;
      XF_NOFAULT:           t[1] = 1'b1;
      XF_RANGE:             t[2] = 1'b1;
      XF_ALIGN, XF_PROTECT: t[3] = 1'b1;
      default:              t = '0;
    endcase
    return t;
  endfunction

  function automatic logic xg_records(input xg_fault_e f);
    return (f == XF_ALIGN) || (f == XF_RANGE) || (f == XF_PROTECT) ||
           (f == XF_NOFAULT) || (f == XF_PRIV);
  endfunction

  function automatic logic xg_is_miss(input xg_fault_e f);
    return (f == XF_MISS_REAL) || (f == XF_MISS_VIRT);
  endfunction

  function automatic logic [63:0] xg_join_pa(input logic [63:0] frame,
                                             input logic [63:0] pmask,
                                             input logic [63:0] va);
    return (frame & ~pmask) | (va & pmask);
  endfunction

  function automatic logic [63:0] xg_miss_tag(input logic [63:0] va,
                                              input logic [63:0] ctx,
                                              input int unsigned pshift);
    return ((va >> pshift) << pshift) | ctx;
  endfunction

  function automatic logic [STAT_W-1:0] xg_stat_word(input logic was_set,
                                                     input logic wr,
                                                     input xg_ctype_e ct,
                                                     input logic se,
                                                     input logic [FT_W-1:0] ft,
                                                     input logic [TAG_W8-1:0] asi);
    logic [STAT_W-1:0] w;
    w        = '0;
    w[0]     = 1'b1;
    w[1]     = was_set;
    w[2]     = wr;
    w[5:4]   = ct;
    w[6]     = se;
    w[12:7]  = ft;
    w[23:16] = asi;
    return w;
  endfunction

endpackage

// File: rtl/xg_ctx_sel.sv
module xg_ctx_sel import xg_pkg::*; #(
  parameter int          CTX_W   = 13,
  parameter logic [7:0]  NUC_TAG = 8'h04,
  parameter logic [7:0]  PRI_TAG = 8'h80
) (
  input  logic             explicit_acc,
  input  logic             tl_nonzero,
  input  logic             asi_nucleus,
  input  logic             asi_secondary,
  input  logic [7:0]       asi_id,
  input  logic [CTX_W-1:0] ctx_primary,
  input  logic [CTX_W-1:0] ctx_secondary,
  output xg_ctype_e        ctype,
  output logic [CTX_W-1:0] ctx_sel,
  output logic [7:0]       asi_rec
);

  always_comb begin
    asi_rec = explicit_acc ? asi_id : (tl_nonzero ? NUC_TAG : PRI_TAG);
    if (tl_nonzero || (explicit_acc && asi_nucleus)) begin
      ctype   = XC_NUCLEUS;
      ctx_sel = '0;
    end else if (explicit_acc && asi_secondary) begin
      ctype   = XC_SECONDARY;
      ctx_sel = ctx_secondary;
    end else begin
      ctype   = XC_PRIMARY;
      ctx_sel = ctx_primary;
    end
  end

endmodule

// File: rtl/xg_pre_check.sv
module xg_pre_check #(
  parameter int              VA_W    = 64,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic            is_data,
  input  logic            explicit_acc,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      size_lg,
  input  logic            addr_mask,
  input  logic            hpriv_mode,
  input  logic            red_mode,
  input  logic            immu_on,
  input  logic            dmmu_on,
  input  logic            asi_real,
  input  logic            asi_as_user,
  output logic [VA_W-1:0] va_eff,
  output logic            misalign,
  output logic            out_of_range,
  output logic            bypass,
  output logic            real_mode
);

  localparam int HI_PAD = VA_W - 32;

  logic [2:0] low_mask;

  always_comb begin
    case (size_lg)
      2'd0:    low_mask = 3'b000;
      2'd1:    low_mask = 3'b001;
      2'd2:    low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
  end

  assign va_eff       = addr_mask ? {{HI_PAD{1'b0}}, va[31:0]} : va;
  assign misalign     = is_data ? |(va[2:0] & low_mask) : |va[2:0];
  assign out_of_range = !addr_mask && (va_eff >= HOLE_LO) && (va_eff <= HOLE_HI);

  always_comb begin
    if (is_data) begin
      bypass    = hpriv_mode && (!explicit_acc || (!asi_real && !asi_as_user));
      real_mode = (!dmmu_on && !hpriv_mode) || (explicit_acc && asi_real);
    end else begin
      bypass    = hpriv_mode || red_mode;
      real_mode = !immu_on;
    end
  end

endmodule

// File: rtl/xg_resolve.sv
module xg_resolve import xg_pkg::*; #(
  parameter int VA_W = 64,
  parameter int PA_W = 40
) (
  input  logic            is_data,
  input  logic            explicit_acc,
  input  logic            acc_write,
  input  logic            priv_mode,
  input  logic            asi_nofault,
  input  logic            misalign,
  input  logic            out_of_range,
  input  logic            bypass,
  input  logic            real_mode,
  input  logic [VA_W-1:0] va_eff,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_frame,
  input  logic [PA_W-1:0] tlb_pmask,
  input  logic            tlb_wr_ok,
  input  logic            tlb_nofault,
  input  logic            tlb_sidefx,
  input  logic            tlb_priv,
  output xg_fault_e       fault,
  output logic            lookup_go,
  output logic            hit_fault,
  output logic [PA_W-1:0] pa,
  output logic            uncache
);

  assign lookup_go = !bypass && !misalign && !out_of_range;

  always_comb begin
    hit_fault = 1'b0;
    if (!is_data && bypass)                                   fault = XF_NONE;
    else if (misalign)                                        fault = XF_ALIGN;
    else if (out_of_range)                                    fault = XF_RANGE;
    else if (bypass)                                          fault = XF_NONE;
    else if (!tlb_hit)                                        fault = real_mode ? XF_MISS_REAL : XF_MISS_VIRT;
    else if (is_data && acc_write && !tlb_wr_ok) begin        fault = XF_PROTECT; hit_fault = 1'b1; end
    else if (is_data && tlb_nofault && !(explicit_acc && asi_nofault)) begin
                                                              fault = XF_NOFAULT; hit_fault = 1'b1; end
    else if (!priv_mode && tlb_priv) begin                    fault = XF_PRIV;    hit_fault = 1'b1; end
    else                                                      fault = XF_NONE;
  end

  always_comb begin
    if (bypass) pa = va_eff[PA_W-1:0];
    else        pa = PA_W'(xg_join_pa(64'(tlb_frame), 64'(tlb_pmask), 64'(va_eff)));
  end

  assign uncache = is_data && lookup_go && tlb_hit && tlb_sidefx && (fault == XF_NONE);

endmodule

// File: rtl/xg_status_regs.sv
module xg_status_regs #(
  parameter int VA_W   = 64,
  parameter int STAT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_word,
  input  logic              addr_we,
  input  logic [VA_W-1:0]   addr_val,
  input  logic              tag_we,
  input  logic [VA_W-1:0]   tag_val,
  output logic [STAT_W-1:0] stat_q,
  output logic [VA_W-1:0]   addr_q,
  output logic [VA_W-1:0]   tag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= stat_word;
    else if (clr)     stat_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_we) addr_q <= addr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tag_we) tag_q <= tag_val;
  end

endmodule

// File: rtl/xlate_guard.sv
module xlate_guard import xg_pkg::*; #(
  parameter int              VA_W       = 64,
  parameter int              PA_W       = 40,
  parameter int              CTX_W      = 13,
  parameter int              PAGE_SHIFT = 13,
  parameter logic [VA_W-1:0] HOLE_LO    = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI    = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_data,
  input  logic              acc_write,
  input  logic              acc_explicit,
  input  logic [VA_W-1:0]   acc_va,
  input  logic [1:0]        acc_size_lg,
  input  logic [7:0]        asi_id,
  input  logic              asi_nucleus,
  input  logic              asi_secondary,
  input  logic              asi_real,
  input  logic              asi_nofault,
  input  logic              asi_as_user,
  input  logic              tl_nonzero,
  input  logic              priv_mode,
  input  logic              hpriv_mode,
  input  logic              red_mode,
  input  logic              addr_mask,
  input  logic              immu_on,
  input  logic              dmmu_on,
  input  logic [CTX_W-1:0]  ctx_primary,
  input  logic [CTX_W-1:0]  ctx_secondary,
  output logic              tlb_req,
  output logic [VA_W-1:0]   tlb_va,
  output logic [CTX_W-1:0]  tlb_ctx,
  output logic              tlb_real,
  input  logic              tlb_hit,
  input  logic [PA_W-1:0]   tlb_frame,
  input  logic [PA_W-1:0]   tlb_pmask,
  input  logic              tlb_wr_ok,
  input  logic              tlb_nofault,
  input  logic              tlb_sidefx,
  input  logic              tlb_priv,
  input  logic              flt_clr,
  output logic [3:0]        fault_code,
  output logic              xlate_ok,
  output logic [PA_W-1:0]   pa_out,
  output logic              uncacheable,
  output logic [STAT_W-1:0] flt_stat,
  output logic [VA_W-1:0]   flt_addr,
  output logic [VA_W-1:0]   miss_tag
);

  logic             expl;
  xg_ctype_e        ctype;
  logic [CTX_W-1:0] ctx_sel;
  logic [7:0]       asi_rec;
  logic [VA_W-1:0]  va_eff;
  logic             misalign, out_of_range, bypass, real_mode;
  xg_fault_e        fault;
  logic             lookup_go, hit_fault, uncache_raw;
  logic [PA_W-1:0]  pa_raw;

  // named events for the checker
  logic              stat_we, addr_we, tag_we, bypass_evt, side_bit;
  logic [STAT_W-1:0] stat_word;

  assign expl = acc_is_data && acc_explicit;

  xg_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
    .explicit_acc (expl),
    .tl_nonzero   (tl_nonzero),
    .asi_nucleus  (asi_nucleus),
    .asi_secondary(asi_secondary),
    .asi_id       (asi_id),
    .ctx_primary  (ctx_primary),
    .ctx_secondary(ctx_secondary),
    .ctype        (ctype),
    .ctx_sel      (ctx_sel),
    .asi_rec      (asi_rec)
  );

  xg_pre_check #(.VA_W(VA_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_pre (
    .is_data     (acc_is_data),
    .explicit_acc(expl),
    .va          (acc_va),
    .size_lg     (acc_size_lg),
    .addr_mask   (addr_mask),
    .hpriv_mode  (hpriv_mode),
    .red_mode    (red_mode),
    .immu_on     (immu_on),
    .dmmu_on     (dmmu_on),
    .asi_real    (asi_real),
    .asi_as_user (asi_as_user),
    .va_eff      (va_eff),
    .misalign    (misalign),
    .out_of_range(out_of_range),
    .bypass      (bypass),
    .real_mode   (real_mode)
  );

  xg_resolve #(.VA_W(VA_W), .PA_W(PA_W)) u_res (
    .is_data     (acc_is_data),
    .explicit_acc(expl),
    .acc_write   (acc_write),
    .priv_mode   (priv_mode),
    .asi_nofault (asi_nofault),
    .misalign    (misalign),
    .out_of_range(out_of_range),
    .bypass      (bypass),
    .real_mode   (real_mode),
    .va_eff      (va_eff),
    .tlb_hit     (tlb_hit),
    .tlb_frame   (tlb_frame),
    .tlb_pmask   (tlb_pmask),
    .tlb_wr_ok   (tlb_wr_ok),
    .tlb_nofault (tlb_nofault),
    .tlb_sidefx  (tlb_sidefx),
    .tlb_priv    (tlb_priv),
    .fault       (fault),
    .lookup_go   (lookup_go),
    .hit_fault   (hit_fault),
    .pa          (pa_raw),
    .uncache     (uncache_raw)
  );

  assign tlb_req     = acc_valid && lookup_go;
  assign tlb_va      = va_eff;
  assign tlb_real    = real_mode;
  assign tlb_ctx     = real_mode ? '0 : ctx_sel;
  assign fault_code  = acc_valid ? fault : XF_NONE;
  assign xlate_ok    = acc_valid && (fault == XF_NONE);
  assign pa_out      = xlate_ok ? pa_raw : '0;
  assign uncacheable = acc_valid && uncache_raw;
  assign bypass_evt  = acc_valid && bypass && (fault == XF_NONE);

  assign side_bit  = acc_is_data && ((fault == XF_RANGE) || (hit_fault && tlb_sidefx));
  assign stat_we   = acc_valid && xg_records(fault);
  assign addr_we   = stat_we && acc_is_data;
  assign tag_we    = acc_valid && xg_is_miss(fault);
  assign stat_word = xg_stat_word(flt_stat[0] && !flt_clr, acc_is_data && acc_write,
                                  ctype, side_bit, xg_ftype(fault), asi_rec);

  xg_status_regs #(.VA_W(VA_W), .STAT_W(STAT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flt_clr),
    .stat_we  (stat_we),
    .stat_word(stat_word),
    .addr_we  (addr_we),
    .addr_val (acc_va),
    .tag_we   (tag_we),
    .tag_val  (VA_W'(xg_miss_tag(64'(va_eff), 64'(tlb_ctx), PAGE_SHIFT))),
    .stat_q   (flt_stat),
    .addr_q   (flt_addr),
    .tag_q    (miss_tag)
  );

endmodule

// File: rtl/xlate_guard_chk.sv
module xlate_guard_chk #(
  parameter int VA_W   = 64,
  parameter int CTX_W  = 13,
  parameter int STAT_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              flt_clr,
  input logic [3:0]        fault_code,
  input logic              xlate_ok,
  input logic              tlb_req,
  input logic              tlb_real,
  input logic [CTX_W-1:0]  tlb_ctx,
  input logic              uncacheable,
  input logic [STAT_W-1:0] flt_stat,
  input logic [VA_W-1:0]   flt_addr,
  input logic [VA_W-1:0]   miss_tag,
  input logic              stat_we,
  input logic              addr_we,
  input logic              tag_we,
  input logic              bypass_evt
);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (fault_code == 4'd0) && !tlb_req && !xlate_ok && !uncacheable);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !flt_clr) |=> $stable(flt_stat) && $stable(flt_addr) && $stable(miss_tag));

  p_bypass_no_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_evt |-> !tlb_req && xlate_ok);

  p_real_ctx_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && tlb_real) |-> (tlb_ctx == '0));

  p_tag_only_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_we |=> $stable(miss_tag));

  p_ok_means_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_ok |-> acc_valid && (fault_code == 4'd0));

  p_uncache_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uncacheable |-> xlate_ok);

  p_stat_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> flt_stat[0]);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && flt_stat[0] && !flt_clr) |=> flt_stat[1]);

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(flt_addr));

  p_clear_alone_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !stat_we) |=> (flt_stat == '0));

  p_clear_with_fault_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && stat_we) |=> flt_stat[0] && !flt_stat[1]);

endmodule

bind xlate_guard xlate_guard_chk #(.VA_W(VA_W), .CTX_W(CTX_W), .STAT_W(xg_pkg::STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .flt_clr    (flt_clr),
  .fault_code (fault_code),
  .xlate_ok   (xlate_ok),
  .tlb_req    (tlb_req),
  .tlb_real   (tlb_real),
  .tlb_ctx    (tlb_ctx),
  .uncacheable(uncacheable),
  .flt_stat   (flt_stat),
  .flt_addr   (flt_addr),
  .miss_tag   (miss_tag),
  .stat_we    (stat_we),
  .addr_we    (addr_we),
  .tag_we     (tag_we),
  .bypass_evt (bypass_evt)
);

// File: tb/tb_xlate_guard.sv
module tb_xlate_guard;

  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] H_LO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] H_HI = 64'hFFFF_7FFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid, acc_is_data, acc_write, acc_explicit;
  logic [63:0] acc_va;
  logic [1:0]  acc_size_lg;
  logic [7:0]  asi_id;
  logic        asi_nucleus, asi_secondary, asi_real, asi_nofault, asi_as_user;
  logic        tl_nonzero, priv_mode, hpriv_mode, red_mode, addr_mask, immu_on, dmmu_on;
  logic [12:0] ctx_primary, ctx_secondary;
  logic        tlb_req, tlb_real;
  logic [63:0] tlb_va;
  logic [12:0] tlb_ctx;
  logic        tlb_hit, tlb_wr_ok, tlb_nofault, tlb_sidefx, tlb_priv;
  logic [39:0] tlb_frame, tlb_pmask;
  logic        flt_clr;
  logic [3:0]  fault_code;
  logic        xlate_ok, uncacheable;
  logic [39:0] pa_out;
  logic [23:0] flt_stat;
  logic [63:0] flt_addr, miss_tag;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // bench-side copies of the three history registers
  logic [23:0] m_stat;
  logic [63:0] m_addr, m_tag;
  // predicted values
  logic [23:0] n_stat;
  logic [63:0] n_addr, n_tag;
  int          e_code;
  logic        e_ok, e_unc, e_req, e_real;
  logic [39:0] e_pa;
  logic [12:0] e_ctx;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_guard dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_data(acc_is_data),
    .acc_write(acc_write), .acc_explicit(acc_explicit), .acc_va(acc_va),
    .acc_size_lg(acc_size_lg), .asi_id(asi_id), .asi_nucleus(asi_nucleus),
    .asi_secondary(asi_secondary), .asi_real(asi_real), .asi_nofault(asi_nofault),
    .asi_as_user(asi_as_user), .tl_nonzero(tl_nonzero), .priv_mode(priv_mode),
    .hpriv_mode(hpriv_mode), .red_mode(red_mode), .addr_mask(addr_mask),
    .immu_on(immu_on), .dmmu_on(dmmu_on), .ctx_primary(ctx_primary),
    .ctx_secondary(ctx_secondary), .tlb_req(tlb_req), .tlb_va(tlb_va),
    .tlb_ctx(tlb_ctx), .tlb_real(tlb_real), .tlb_hit(tlb_hit),
    .tlb_frame(tlb_frame), .tlb_pmask(tlb_pmask), .tlb_wr_ok(tlb_wr_ok),
    .tlb_nofault(tlb_nofault), .tlb_sidefx(tlb_sidefx), .tlb_priv(tlb_priv),
    .flt_clr(flt_clr), .fault_code(fault_code), .xlate_ok(xlate_ok),
    .pa_out(pa_out), .uncacheable(uncacheable), .flt_stat(flt_stat),
    .flt_addr(flt_addr), .miss_tag(miss_tag)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic defaults();
    acc_valid = 1; acc_is_data = 0; acc_write = 0; acc_explicit = 0;
    acc_va = 64'h0000_0000_4000_2008; acc_size_lg = 2'd3; asi_id = 8'h00;
    asi_nucleus = 0; asi_secondary = 0; asi_real = 0; asi_nofault = 0; asi_as_user = 0;
    tl_nonzero = 0; priv_mode = 1; hpriv_mode = 0; red_mode = 0; addr_mask = 0;
    immu_on = 1; dmmu_on = 1; ctx_primary = 13'h0123; ctx_secondary = 13'h0456;
    tlb_hit = 1; tlb_frame = 40'h12_3456_7000; tlb_pmask = 40'h0_0000_1FFF;
    tlb_wr_ok = 1; tlb_nofault = 0; tlb_sidefx = 0; tlb_priv = 0; flt_clr = 0;
  endtask

  // behavioural reference: derives every expectation from the requirement text
  task automatic predict();
    int          ctype;
    logic [12:0] cx;
    logic [7:0]  rec;
    logic [63:0] vae;
    longint unsigned bytes;
    bit mis, rng, byp, rl, expl, hitflt, se, wrb;
    int ft_bit;
    expl = acc_is_data && acc_explicit;
    if (tl_nonzero || (expl && asi_nucleus)) begin ctype = 2; cx = 0; end
    else if (expl && asi_secondary)        begin ctype = 1; cx = ctx_secondary; end
    else                                   begin ctype = 0; cx = ctx_primary; end
    rec = expl ? asi_id : (tl_nonzero ? 8'h04 : 8'h80);
    vae = addr_mask ? (acc_va % 64'h1_0000_0000) : acc_va;
    bytes = acc_is_data ? (64'd1 << acc_size_lg) : 64'd8;
    mis = (acc_va % bytes) != 0;
    rng = !addr_mask && vae >= H_LO && vae <= H_HI;
    if (acc_is_data) begin
      byp = hpriv_mode && (!expl || (!asi_real && !asi_as_user));
      rl  = (!dmmu_on && !hpriv_mode) || (expl && asi_real);
    end else begin
      byp = hpriv_mode || red_mode;
      rl  = !immu_on;
    end
    e_real = rl;
    e_ctx  = rl ? 13'd0 : cx;
    hitflt = 0;
    if (!acc_is_data && byp) e_code = 0;
    else if (mis) e_code = 1;
    else if (rng) e_code = 2;
    else if (byp) e_code = 0;
    else if (!tlb_hit) e_code = rl ? 3 : 4;
    else if (acc_is_data && acc_write && !tlb_wr_ok) begin e_code = 5; hitflt = 1; end
    else if (acc_is_data && tlb_nofault && !(expl && asi_nofault)) begin e_code = 6; hitflt = 1; end
    else if (!priv_mode && tlb_priv) begin e_code = 7; hitflt = 1; end
    else e_code = 0;
    e_req = acc_valid && !byp && !mis && !rng;
    if (!acc_valid) e_code = 0;
    e_ok  = acc_valid && e_code == 0;
    if (!e_ok) e_pa = 0;
    else if (byp) e_pa = vae[39:0];
    else e_pa = (tlb_frame & ~tlb_pmask) | (vae[39:0] & tlb_pmask);
    e_unc = e_ok && acc_is_data && !byp && tlb_sidefx;
    // history registers
    n_stat = flt_clr ? 24'd0 : m_stat;
    n_addr = m_addr;
    n_tag  = m_tag;
    if (acc_valid && (e_code == 3 || e_code == 4))
      n_tag = {vae[63:13], 13'd0} | {51'd0, e_ctx};
    if (acc_valid && e_code inside {1, 2, 5, 6, 7}) begin
      case (e_code)
        7: ft_bit = 7;
        6: ft_bit = 8;
        2: ft_bit = 9;
        default: ft_bit = 10;
      endcase
      se  = acc_is_data && (e_code == 2 || (hitflt && tlb_sidefx));
      wrb = acc_is_data && acc_write;
      n_stat = 24'd1 | (24'd1 << ft_bit) | ({16'd0, rec} << 16) | (24'(ctype) << 4);
      if (m_stat[0] && !flt_clr) n_stat = n_stat | 24'd2;
      if (wrb) n_stat = n_stat | 24'd4;
      if (se)  n_stat = n_stat | 24'd64;
      if (acc_is_data) n_addr = acc_va;
    end
  endtask

  task automatic step(input string tag);
    predict();
    #2;
    check(tag, "fault_code", 64'(fault_code), 64'(e_code));
    check(tag, "xlate_ok", 64'(xlate_ok), 64'(e_ok));
    check(tag, "pa_out", 64'(pa_out), 64'(e_pa));
    check(tag, "uncacheable", 64'(uncacheable), 64'(e_unc));
    check(tag, "tlb_req", 64'(tlb_req), 64'(e_req));
    if (e_req) begin
      check(tag, "tlb_ctx", 64'(tlb_ctx), 64'(e_ctx));
      check(tag, "tlb_real", 64'(tlb_real), 64'(e_real));
    end
    @(posedge clk); #1;
    m_stat = n_stat; m_addr = n_addr; m_tag = n_tag;
    check(tag, "flt_stat", 64'(flt_stat), 64'(m_stat));
    check(tag, "flt_addr", flt_addr, m_addr);
    check(tag, "miss_tag", miss_tag, m_tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    defaults();
    acc_valid = 0;
    m_stat = 0; m_addr = 0; m_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R13", "reset flt_stat", 64'(flt_stat), 64'd0);
    check("R13", "reset flt_addr", flt_addr, 64'd0);
    check("R13", "reset miss_tag", miss_tag, 64'd0);
    check("R13", "idle fault_code", 64'(fault_code), 64'd0);

    // R1 R9: primary fetch, then nucleus under trap level
    defaults(); step("R9");
    defaults(); tl_nonzero = 1; step("R1");
    // R3 alignment on fetch, R10 status word, then R11 overflow
    defaults(); acc_va = 64'h4000_2004; step("R3");
    defaults(); acc_va = 64'h4000_2001; tl_nonzero = 1; step("R11");
    // R14 lone clear, then clear with fault
    defaults(); acc_valid = 0; flt_clr = 1; step("R14");
    defaults(); acc_va = 64'h4000_2002; step("R10");
    defaults(); acc_va = 64'h4000_2002; flt_clr = 1; step("R14");
    // R1 secondary class data; R12 data alignment fault latches address
    defaults(); acc_is_data = 1; acc_explicit = 1; asi_secondary = 1; asi_id = 8'h81; step("R1");
    defaults(); acc_is_data = 1; acc_size_lg = 2; acc_va = 64'h4000_2006; acc_write = 1;
      asi_id = 8'h11; acc_explicit = 1; asi_secondary = 1; step("R12");
    defaults(); acc_is_data = 1; acc_size_lg = 1; acc_va = 64'h4000_2006; step("R3");
    // R4 hole and its edges, masking
    defaults(); acc_is_data = 1; acc_va = H_LO; step("R4");
    defaults(); acc_is_data = 1; acc_va = H_LO - 64'd8; step("R4");
    defaults(); acc_va = H_HI - 64'd7; step("R4");
    defaults(); acc_va = H_HI + 64'd1; step("R4");
    defaults(); acc_is_data = 1; acc_va = H_LO | 64'h1000; addr_mask = 1; step("R4");
    // R2 bypasses
    defaults(); hpriv_mode = 1; acc_va = 64'hFFFF_FFFF_FFFF_FFF3; step("R2");
    defaults(); red_mode = 1; acc_va = 64'h0000_00AB_CDEF_0120; step("R2");
    defaults(); acc_is_data = 1; hpriv_mode = 1; acc_va = 64'h0000_0012_3456_7890; step("R2");
    defaults(); acc_is_data = 1; hpriv_mode = 1; acc_size_lg = 3; acc_va = 64'h44; step("R2");
    defaults(); acc_is_data = 1; hpriv_mode = 1; acc_explicit = 1; asi_as_user = 1; step("R2");
    // R5 real lookups and R6 misses
    defaults(); acc_is_data = 1; hpriv_mode = 1; acc_explicit = 1; asi_real = 1; tlb_hit = 0; step("R5");
    defaults(); acc_is_data = 1; dmmu_on = 0; tlb_hit = 0; step("R6");
    defaults(); immu_on = 0; step("R5");
    defaults(); tlb_hit = 0; acc_va = 64'h0000_0007_FFFF_E000; step("R6");
    defaults(); tlb_hit = 0; acc_is_data = 1; acc_explicit = 1; asi_secondary = 1; step("R6");
    // R7 priority on a hit, R8 uncacheable
    defaults(); acc_is_data = 1; acc_write = 1; tlb_wr_ok = 0; tlb_nofault = 1; tlb_priv = 1;
      priv_mode = 0; tlb_sidefx = 1; step("R7");
    defaults(); acc_is_data = 1; tlb_nofault = 1; tlb_priv = 1; priv_mode = 0; step("R7");
    defaults(); acc_is_data = 1; tlb_nofault = 1; acc_explicit = 1; asi_nofault = 1;
      tlb_priv = 1; priv_mode = 0; tlb_sidefx = 1; step("R7");
    defaults(); tlb_nofault = 1; acc_write = 1; tlb_wr_ok = 0; step("R7");
    defaults(); acc_is_data = 1; tlb_sidefx = 1; step("R8");
    defaults(); tlb_sidefx = 1; step("R8");
    defaults(); tlb_pmask = 40'h0_003F_FFFF; acc_va = 64'h0000_0001_2345_6788; step("R9");
    // R13 an invalid strobe with a faulting address changes nothing
    defaults(); acc_valid = 0; acc_va = 64'h3; tlb_hit = 0; step("R13");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      defaults();
      acc_valid = ($urandom % 8) != 0;
      acc_is_data = $urandom % 2; acc_write = $urandom % 2; acc_explicit = $urandom % 2;
      acc_size_lg = 2'($urandom % 4); asi_id = 8'($urandom);
      asi_nucleus = ($urandom % 4) == 0; asi_secondary = $urandom % 2;
      asi_real = ($urandom % 4) == 0; asi_nofault = $urandom % 2; asi_as_user = ($urandom % 4) == 0;
      tl_nonzero = $urandom % 2; priv_mode = $urandom % 2; hpriv_mode = ($urandom % 5) == 0;
      red_mode = ($urandom % 6) == 0; addr_mask = ($urandom % 4) == 0;
      immu_on = ($urandom % 4) != 0; dmmu_on = ($urandom % 4) != 0;
      ctx_primary = 13'($urandom); ctx_secondary = 13'($urandom);
      tlb_hit = ($urandom % 4) != 0; tlb_frame = {8'($urandom), 32'($urandom)};
      tlb_pmask = ($urandom % 2) ? 40'h1FFF : 40'h3F_FFFF;
      tlb_wr_ok = $urandom % 2; tlb_nofault = ($urandom % 4) == 0;
      tlb_sidefx = $urandom % 2; tlb_priv = $urandom % 2; flt_clr = ($urandom % 5) == 0;
      case ($urandom % 6)
        0: acc_va = {32'd0, $urandom} & ~64'h7;
        1: acc_va = {$urandom, $urandom};
        2: acc_va = H_LO;
        3: acc_va = H_HI + 64'd1;
        4: acc_va = {32'd0, $urandom};
        default: acc_va = 64'h0000_7FFF_FFFF_FFF8;
      endcase
      step("R1/R7/R10/R11");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule